// File: doc/BRIEF.md
# Serial Clock Mode Detector

This block decides what a single multi-purpose input pin is being used for. The pin either carries a running bit clock from an external source, or it is tied to a fixed level that selects de-emphasis. The decision comes from counting the pin's rising edges against the frame (left/right) clock. Everything is clocked by the fast master clock. The frame clock and the shared pin are asynchronous inputs. Each passes through its own two-flop synchronizer, and edges are found on the synchronized copies.

A burst of rising edges inside one half of the frame clock marks the pin as an external bit clock, and the block enters external mode. If the pin goes quiet for two whole frames, the block falls back to internal mode. In internal mode, the downstream serial logic makes its own bit clock. The pin's static level then turns de-emphasis on (high) or off (low). Each mode change produces a single-cycle pulse. All pins are plain level or pulse signals, so there is no handshake or back-pressure.

Top module: `bitclk_mode_sense`

## Requirements
- R1: The mode flag goes to external (`ext_mode_o`=1) once `EDGE_THRESH` (default 16) synchronized rising edges of the shared pin fall inside one frame-clock phase. A phase runs from any frame-clock edge to the next. With `EDGE_THRESH`-1 edges per phase, the mode stays internal.
- R2: The mode flag returns to internal (`ext_mode_o`=0) when `IDLE_FRAMES` (default 2) frame-clock rising edges pass with no pin rising edge in between. After only one such frame, the mode stays external.
- R3: While in external mode, `deemph_en_o` is 0 whatever level the pin holds.
- R4: While in internal mode, `deemph_en_o` equals the synchronized pin level: 1 for high, 0 for low.
- R5: The per-phase edge count is cleared at every frame-clock edge. Edges split across two phases, none of which reaches the threshold alone, do not select external mode.
- R6: The per-phase edge count saturates at the threshold. Further edges in the same phase or in later phases cause no extra mode-change pulse.
- R7: `mode_chg_o` is high for exactly one cycle in the cycle the mode flag takes its new value. It never pulses when the mode is unchanged.
- R8: After reset the block is in internal mode, with `deemph_en_o`=0, `mode_chg_o`=0 and both counters cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_clk_i | input | 1 | Frame (left/right) clock, asynchronous |
| share_pin_i | input | 1 | Shared bit-clock / de-emphasis select pin, asynchronous |
| ext_mode_o | output | 1 | 1 = external bit clock mode, 0 = internal mode |
| deemph_en_o | output | 1 | De-emphasis enable |
| mode_chg_o | output | 1 | One-cycle pulse on each mode change |

## Verification
The assertions assume that each input stays at a level for at least two master clock cycles. Without that, the synchronizers could lose a pulse and the edge counts would no longer follow the pin. They also assume that the pin's rising edges stop well before a frame-clock edge if those edges are meant to count in that phase. The stimulus holds every pin pulse high for two cycles and low for two cycles. It fits at most twenty pulses into a hundred-cycle phase, so each burst ends long before the next frame-clock edge.

// File: rtl/bcm_pkg.sv
package bcm_pkg;
  typedef enum logic {
    MODE_INT = 1'b0,
    MODE_EXT = 1'b1
  } sclk_mode_e;
endpackage

// File: rtl/bcm_sync.sv
module bcm_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/bcm_edge_det.sv
module bcm_edge_det #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sig_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] any_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig_i;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign rise_o[b] = sig_i[b] & ~prev_q[b];
    assign any_o[b]  = sig_i[b] ^ prev_q[b];
  end
endmodule

// File: rtl/bcm_phase_counter.sv
module bcm_phase_counter #(
  parameter int THRESH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phase_edge_i,
  input  logic pin_rise_i,
  output logic thr_hit_o
);
  localparam int CW = $clog2(THRESH + 1);
  localparam logic [CW-1:0] LAST = CW'(THRESH - 1);
  localparam logic [CW-1:0] TOP  = CW'(THRESH);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (phase_edge_i) begin
      cnt_q <= pin_rise_i ? CW'(1) : '0;
    end else if (pin_rise_i && cnt_q != TOP) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  always_comb begin
    if (!pin_rise_i)       thr_hit_o = 1'b0;
    else if (phase_edge_i) thr_hit_o = (THRESH == 1);
    else                   thr_hit_o = (cnt_q == LAST);
  end

  assert_cnt_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);

  assert_phase_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_edge_i && !pin_rise_i) |=> (cnt_q == '0));
endmodule

// File: rtl/bcm_frame_timer.sv
module bcm_frame_timer #(
  parameter int FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_rise_i,
  input  logic pin_rise_i,
  output logic idle_hit_o
);
  localparam int FW = $clog2(FRAMES + 1);
  localparam logic [FW-1:0] LAST = FW'(FRAMES - 1);
  localparam logic [FW-1:0] TOP  = FW'(FRAMES);

  logic [FW-1:0] fcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q <= '0;
    end else if (pin_rise_i) begin
      fcnt_q <= '0;
    end else if (frame_rise_i && fcnt_q != TOP) begin
      fcnt_q <= fcnt_q + FW'(1);
    end
  end

  assign idle_hit_o = frame_rise_i && !pin_rise_i && (fcnt_q == LAST);

  assert_fcnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt_q <= TOP);

  assert_fcnt_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pin_rise_i |=> (fcnt_q == '0));
endmodule

// File: rtl/bitclk_mode_sense.sv
module bitclk_mode_sense #(
  parameter int EDGE_THRESH = 16,
  parameter int IDLE_FRAMES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_clk_i,
  input  logic share_pin_i,
  output logic ext_mode_o,
  output logic deemph_en_o,
  output logic mode_chg_o
);
  import bcm_pkg::*;

  localparam int NSIG    = 2;
  localparam int IDX_PIN = 0;
  localparam int IDX_FRM = 1;

  logic [NSIG-1:0] raw, synced, rises, toggles;
  logic            thr_hit, idle_hit;
  sclk_mode_e      mode_q, mode_nxt;
  logic            chg_q;

  assign raw[IDX_PIN] = share_pin_i;
  assign raw[IDX_FRM] = frame_clk_i;

  bcm_sync #(.STAGES(SYNC_STAGES), .WIDTH(NSIG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(synced)
  );

  bcm_edge_det #(.WIDTH(NSIG)) u_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(synced), .rise_o(rises), .any_o(toggles)
  );

  bcm_phase_counter #(.THRESH(EDGE_THRESH)) u_phase (
    .clk(clk), .rst_n(rst_n),
    .phase_edge_i(toggles[IDX_FRM]), .pin_rise_i(rises[IDX_PIN]),
    .thr_hit_o(thr_hit)
  );

  bcm_frame_timer #(.FRAMES(IDLE_FRAMES)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .frame_rise_i(rises[IDX_FRM]), .pin_rise_i(rises[IDX_PIN]),
    .idle_hit_o(idle_hit)
  );

  always_comb begin
    mode_nxt = mode_q;
    if (thr_hit)       mode_nxt = MODE_EXT;
    else if (idle_hit) mode_nxt = MODE_INT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_INT;
      chg_q  <= 1'b0;
    end else begin
      mode_q <= mode_nxt;
      chg_q  <= (mode_nxt != mode_q);
    end
  end

  assign ext_mode_o  = (mode_q == MODE_EXT);
  assign deemph_en_o = (mode_q == MODE_INT) && synced[IDX_PIN];
  assign mode_chg_o  = chg_q;

  assert_pulse_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg_o |=> !mode_chg_o);

  assert_pulse_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg_o |-> (ext_mode_o != $past(ext_mode_o)));

  assert_ext_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_mode_o) |-> $past(thr_hit));

  assert_int_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_mode_o) |-> $past(idle_hit));
endmodule

// File: tb/bitclk_mode_sense_tb_top.sv
module bitclk_mode_sense_tb_top;
  localparam int PHASE = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_clk = 1'b0;
  logic share_pin = 1'b0;
  logic ext_mode, deemph_en, mode_chg;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  int wide = 0;
  int frame_rises = 0;
  logic chg_prev = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bitclk_mode_sense dut_i (
    .clk(clk), .rst_n(rst_n),
    .frame_clk_i(frame_clk), .share_pin_i(share_pin),
    .ext_mode_o(ext_mode), .deemph_en_o(deemph_en), .mode_chg_o(mode_chg)
  );

  always @(posedge clk) begin
    #2;
    if (mode_chg) pulses++;
    if (mode_chg && chg_prev) wide++;
    chg_prev = mode_chg;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_phase(int rises, bit hold);
    frame_clk = ~frame_clk;
    if (frame_clk) frame_rises++;
    for (int i = 0; i < rises; i++) begin
      share_pin = 1'b1;
      repeat (2) @(negedge clk);
      share_pin = 1'b0;
      repeat (2) @(negedge clk);
    end
    share_pin = hold;
    repeat (PHASE - 4*rises) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R8", "ext_mode after reset", ext_mode, 0);
    chk("R8", "deemph after reset", deemph_en, 0);
    chk("R8", "mode_chg after reset", mode_chg, 0);
  endtask

  task automatic t_int_deemph;
    run_phase(0, 1'b1);
    chk("R4", "deemph with pin high, internal", deemph_en, 1);
    run_phase(0, 1'b0);
    chk("R4", "deemph with pin low, internal", deemph_en, 0);
  endtask

  task automatic t_below;
    int p0 = pulses;
    for (int i = 0; i < 4; i++) run_phase(15, 1'b0);
    chk("R1", "ext_mode with 15 edges per phase", ext_mode, 0);
    chk("R1", "no pulse below threshold", pulses - p0, 0);
  endtask

  task automatic t_split;
    int p0 = pulses;
    for (int i = 0; i < 4; i++) run_phase(10, 1'b0);
    chk("R5", "ext_mode with edges split over phases", ext_mode, 0);
    chk("R5", "no pulse on split edges", pulses - p0, 0);
  endtask

  task automatic t_enter;
    int p0 = pulses;
    run_phase(16, 1'b0);
    chk("R1", "ext_mode after 16 edges in a phase", ext_mode, 1);
    chk("R7", "one pulse on entering external", pulses - p0, 1);
    chk("R7", "pulse width one cycle", wide, 0);
  endtask

  task automatic t_ext_deemph;
    run_phase(0, 1'b1);
    chk("R3", "still external after one quiet phase", ext_mode, 1);
    chk("R3", "deemph forced low in external, pin high", deemph_en, 0);
  endtask

  task automatic t_saturate;
    int p0 = pulses;
    for (int i = 0; i < 6; i++) run_phase(20, 1'b1);
    chk("R6", "ext_mode after many full phases", ext_mode, 1);
    chk("R6", "no extra pulses past threshold", pulses - p0, 0);
  endtask

  task automatic t_timeout;
    int p0 = pulses;
    int f0 = frame_rises;
    while (frame_rises - f0 < 1) run_phase(0, 1'b1);
    chk("R2", "still external after one quiet frame", ext_mode, 1);
    chk("R2", "no pulse after one quiet frame", pulses - p0, 0);
    while (frame_rises - f0 < 2) run_phase(0, 1'b1);
    chk("R2", "internal after two quiet frames", ext_mode, 0);
    chk("R7", "one pulse on return to internal", pulses - p0, 1);
    chk("R4", "deemph follows high pin after return", deemph_en, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_int_deemph();
    t_below();
    t_split();
    t_enter();
    t_ext_deemph();
    t_saturate();
    t_timeout();
    chk("R7", "no pulse ever wider than one cycle", wide, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule